// File: doc/BRIEF.md
# Single-Flit Router Node for a One-Way 2D Torus

This block is one node of a two-dimensional torus network in which every ring link runs in one direction only. The node has a horizontal ring input and output, a vertical ring input and output, and a local port that injects and ejects flits. Every flit stands alone and carries its destination column and row next to its payload. A flit first follows the horizontal ring until the column matches. It then follows the vertical ring until the row matches, and there it leaves through the local port.

A flit that keeps its direction passes through in one registered cycle and is never stored. The only storage is a small queue. It holds flits that leave the horizontal ring to continue vertically, plus locally injected flits that start out vertically. The ring links have no handshake. When the queue is full, a turning flit stays on the horizontal ring and tries again on its next lap. When a vertical flit has already taken the ejection port, a flit that would eject from the horizontal ring does the same. Local injection uses a valid/ready handshake and gets only resources that ring traffic leaves unused.

Top module: `torus_node`

## Requirements
- R1: A flit is packed as {column[CRD_W], row[CRD_W], payload[PLD_W]}, with the column in the most significant bits. A horizontal-input flit whose column differs from X_POS appears unchanged on the horizontal output one cycle later.
- R2: A vertical-input flit whose row differs from Y_POS appears unchanged on the vertical output one cycle later. Vertical through-traffic always takes the vertical output ahead of the turn queue.
- R3: A vertical-input flit whose row equals Y_POS is ejected one cycle later. It wins the ejection port over any other source.
- R4: A horizontal-input flit addressed to this node (column X_POS, row Y_POS) is ejected one cycle later if no vertical flit ejects in the same cycle. Otherwise it appears on the horizontal output one cycle later.
- R5: A horizontal-input flit with column X_POS and a row other than Y_POS enters the turn queue if the queue is not full. Queued flits leave on the vertical output in arrival order. The earliest a queued flit can leave is two cycles after it arrived, and it leaves only in cycles without vertical through-traffic.
- R6: When the turn queue holds FIFO_DEPTH flits, a turning horizontal-input flit appears on the horizontal output one cycle later.
- R7: A local flit bound for another column sees ready high exactly when no ring flit claims the horizontal output in that cycle. Once accepted, it appears on the horizontal output one cycle later.
- R8: A local flit with column X_POS and another row sees ready high exactly when the queue is not full and no horizontal flit turns in the same cycle. Once accepted, it enters the turn queue.
- R9: A local flit addressed to this node sees ready high exactly when no ring flit ejects in that cycle. Once accepted, it is ejected one cycle later.
- R10: While reset is asserted, all output valids and the injection ready are low, and the turn queue is emptied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| x_in_vld | input | 1 | Horizontal ring input valid |
| x_in_flit | input | FLIT_W | Horizontal ring input flit |
| y_in_vld | input | 1 | Vertical ring input valid |
| y_in_flit | input | FLIT_W | Vertical ring input flit |
| x_out_vld | output | 1 | Horizontal ring output valid |
| x_out_flit | output | FLIT_W | Horizontal ring output flit |
| y_out_vld | output | 1 | Vertical ring output valid |
| y_out_flit | output | FLIT_W | Vertical ring output flit |
| inj_vld | input | 1 | Local injection valid |
| inj_flit | input | FLIT_W | Local injection flit |
| inj_rdy | output | 1 | Local injection ready |
| ej_vld | output | 1 | Ejection valid, one cycle per flit |
| ej_flit | output | FLIT_W | Ejected flit |

## Verification
A corrupted turn-queue pointer or count shows up on the vertical output. Drained flits come out in the wrong order or are duplicated, or the full-queue overflow onto the horizontal ring happens one flit early or late. This is visible within FIFO_DEPTH+2 cycles of the first turn. A wrong arbitration choice shows one cycle after the conflicting inputs: the wrong flit appears on an output, or inj_rdy has the wrong level in that same cycle. The directed scenarios place each conflict in a known cycle and compare every output in the cycle after it.

// File: rtl/torus_pkg.sv
package torus_pkg;
    parameter int CRD_W  = 4;
    parameter int PLD_W  = 16;
    localparam int FLIT_W = 2 * CRD_W + PLD_W;

    typedef struct packed {
        logic [CRD_W-1:0] col;
        logic [CRD_W-1:0] row;
        logic [PLD_W-1:0] pld;
    } flit_t;

    typedef enum logic [1:0] {
        RT_RING_X = 2'd0,
        RT_TURN   = 2'd1,
        RT_EJECT  = 2'd2
    } route_t;
endpackage

// File: rtl/torus_route_dec.sv
module torus_route_dec
    import torus_pkg::*;
#(
    parameter int X_POS = 0,
    parameter int Y_POS = 0
) (
    input  logic [CRD_W-1:0] col,
    input  logic [CRD_W-1:0] row,
    output route_t           route
);
    always_comb begin
        if (col != CRD_W'(X_POS))      route = RT_RING_X;
        else if (row != CRD_W'(Y_POS)) route = RT_TURN;
        else                           route = RT_EJECT;
    end
endmodule

// File: rtl/torus_turn_fifo.sv
module torus_turn_fifo
    import torus_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [FLIT_W-1:0] push_flit,
    input  logic              pop,
    output logic [FLIT_W-1:0] head_flit,
    output logic              full,
    output logic              empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [FLIT_W-1:0] mem_q [DEPTH];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full      = (ptr_q.cnt == CW'(DEPTH));
    assign empty     = (ptr_q.cnt == '0);
    assign head_flit = mem_q[ptr_q.rd];

    always_comb begin
        ptr_d = ptr_q;
        if (push) ptr_d.wr = bump(ptr_q.wr);
        if (pop)  ptr_d.rd = bump(ptr_q.rd);
        case ({push, pop})
            2'b10:   ptr_d.cnt = ptr_q.cnt + CW'(1);
            2'b01:   ptr_d.cnt = ptr_q.cnt - CW'(1);
            default: ptr_d.cnt = ptr_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[ptr_q.wr] <= push_flit;
    end

    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);
    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> !empty);
endmodule

// File: rtl/torus_node.sv
module torus_node
    import torus_pkg::*;
#(
    parameter int X_DIM      = 3,
    parameter int Y_DIM      = 3,
    parameter int X_POS      = 0,
    parameter int Y_POS      = 0,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              x_in_vld,
    input  logic [FLIT_W-1:0] x_in_flit,
    input  logic              y_in_vld,
    input  logic [FLIT_W-1:0] y_in_flit,
    output logic              x_out_vld,
    output logic [FLIT_W-1:0] x_out_flit,
    output logic              y_out_vld,
    output logic [FLIT_W-1:0] y_out_flit,
    input  logic              inj_vld,
    input  logic [FLIT_W-1:0] inj_flit,
    output logic              inj_rdy,
    output logic              ej_vld,
    output logic [FLIT_W-1:0] ej_flit
);
    typedef struct packed {
        logic              x_vld;
        logic [FLIT_W-1:0] x_flit;
        logic              y_vld;
        logic [FLIT_W-1:0] y_flit;
        logic              e_vld;
        logic [FLIT_W-1:0] e_flit;
    } out_t;

    out_t st_d, st_q;

    flit_t  x_in_s, y_in_s, inj_s;
    route_t x_rt, inj_rt;

    logic              q_push, q_pop, q_full, q_empty;
    logic [FLIT_W-1:0] q_push_flit, q_head;

    assign x_in_s = flit_t'(x_in_flit);
    assign y_in_s = flit_t'(y_in_flit);
    assign inj_s  = flit_t'(inj_flit);

    torus_route_dec #(.X_POS(X_POS), .Y_POS(Y_POS)) x_dec_i (
        .col(x_in_s.col), .row(x_in_s.row), .route(x_rt)
    );
    torus_route_dec #(.X_POS(X_POS), .Y_POS(Y_POS)) inj_dec_i (
        .col(inj_s.col), .row(inj_s.row), .route(inj_rt)
    );

    torus_turn_fifo #(.DEPTH(FIFO_DEPTH)) turn_q_i (
        .clk(clk), .rst_n(rst_n),
        .push(q_push), .push_flit(q_push_flit),
        .pop(q_pop), .head_flit(q_head),
        .full(q_full), .empty(q_empty)
    );

    always_comb begin
        st_d        = '0;
        q_push      = 1'b0;
        q_push_flit = x_in_flit;
        q_pop       = 1'b0;
        inj_rdy     = 1'b0;

        // vertical ring: arrivals either eject or continue
        if (y_in_vld) begin
            if (y_in_s.row == CRD_W'(Y_POS)) begin
                st_d.e_vld  = 1'b1;
                st_d.e_flit = y_in_flit;
            end else begin
                st_d.y_vld  = 1'b1;
                st_d.y_flit = y_in_flit;
            end
        end

        // horizontal ring: never stalls, falls back to circulating
        if (x_in_vld) begin
            unique case (x_rt)
                RT_EJECT: begin
                    if (!st_d.e_vld) begin
                        st_d.e_vld  = 1'b1;
                        st_d.e_flit = x_in_flit;
                    end else begin
                        st_d.x_vld  = 1'b1;
                        st_d.x_flit = x_in_flit;
                    end
                end
                RT_TURN: begin
                    if (!q_full) begin
                        q_push = 1'b1;
                    end else begin
                        st_d.x_vld  = 1'b1;
                        st_d.x_flit = x_in_flit;
                    end
                end
                default: begin
                    st_d.x_vld  = 1'b1;
                    st_d.x_flit = x_in_flit;
                end
            endcase
        end

        // turn queue drains into free vertical slots
        if (!st_d.y_vld && !q_empty) begin
            q_pop       = 1'b1;
            st_d.y_vld  = 1'b1;
            st_d.y_flit = q_head;
        end

        // local injection takes leftovers only
        if (rst_n) begin
            unique case (inj_rt)
                RT_TURN:  inj_rdy = !q_push && !q_full;
                RT_EJECT: inj_rdy = !st_d.e_vld;
                default:  inj_rdy = !st_d.x_vld;
            endcase
        end

        if (inj_vld && inj_rdy) begin
            unique case (inj_rt)
                RT_TURN: begin
                    q_push      = 1'b1;
                    q_push_flit = inj_flit;
                end
                RT_EJECT: begin
                    st_d.e_vld  = 1'b1;
                    st_d.e_flit = inj_flit;
                end
                default: begin
                    st_d.x_vld  = 1'b1;
                    st_d.x_flit = inj_flit;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign x_out_vld  = st_q.x_vld;
    assign x_out_flit = st_q.x_flit;
    assign y_out_vld  = st_q.y_vld;
    assign y_out_flit = st_q.y_flit;
    assign ej_vld     = st_q.e_vld;
    assign ej_flit    = st_q.e_flit;

    // R1: through traffic on the horizontal ring
    a_r1_x_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (x_in_vld && x_in_s.col != CRD_W'(X_POS))
        |=> (x_out_vld && x_out_flit == $past(x_in_flit)));
    // R2: through traffic on the vertical ring
    a_r2_y_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (y_in_vld && y_in_s.row != CRD_W'(Y_POS))
        |=> (y_out_vld && y_out_flit == $past(y_in_flit)));
    // R3: vertical arrivals for this row always eject
    a_r3_y_eject: assert property (@(posedge clk) disable iff (!rst_n)
        (y_in_vld && y_in_s.row == CRD_W'(Y_POS))
        |=> (ej_vld && ej_flit == $past(y_in_flit)));
    // R3: a vertical flit is already in its column
    a_r3_y_column: assert property (@(posedge clk) disable iff (!rst_n)
        y_in_vld |-> (y_in_s.col == CRD_W'(X_POS)));
    // R7: accepted outbound injection appears on the horizontal ring
    a_r7_inj_x: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_vld && inj_rdy && inj_s.col != CRD_W'(X_POS))
        |=> (x_out_vld && x_out_flit == $past(inj_flit)));
    // R7: injected coordinates lie inside the torus
    a_r7_inj_range: assert property (@(posedge clk) disable iff (!rst_n)
        inj_vld |-> (inj_s.col < CRD_W'(X_DIM) && inj_s.row < CRD_W'(Y_DIM)));
    // R10: nothing leaves in the cycle after reset
    a_r10_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!x_out_vld && !y_out_vld && !ej_vld));
endmodule

// File: tb/torus_node_tb.sv
module torus_node_tb_top;
    import torus_pkg::*;

    localparam int XP = 1;
    localparam int YP = 2;
    localparam int QD = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              x_in_vld = 1'b0, y_in_vld = 1'b0, inj_vld = 1'b0;
    logic [FLIT_W-1:0] x_in_flit = '0, y_in_flit = '0, inj_flit = '0;
    logic              x_out_vld, y_out_vld, ej_vld, inj_rdy;
    logic [FLIT_W-1:0] x_out_flit, y_out_flit, ej_flit;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    torus_node #(.X_DIM(3), .Y_DIM(3), .X_POS(XP), .Y_POS(YP),
                 .FIFO_DEPTH(QD)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .x_in_vld(x_in_vld), .x_in_flit(x_in_flit),
        .y_in_vld(y_in_vld), .y_in_flit(y_in_flit),
        .x_out_vld(x_out_vld), .x_out_flit(x_out_flit),
        .y_out_vld(y_out_vld), .y_out_flit(y_out_flit),
        .inj_vld(inj_vld), .inj_flit(inj_flit), .inj_rdy(inj_rdy),
        .ej_vld(ej_vld), .ej_flit(ej_flit)
    );

    function automatic logic [FLIT_W-1:0] mk(input int c, input int r, input int p);
        return {CRD_W'(c), CRD_W'(r), PLD_W'(p)};
    endfunction

    task automatic chk(input logic ok, input string req, input logic [FLIT_W:0] act,
                       input logic [FLIT_W:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input logic v, input logic [FLIT_W-1:0] f,
                           input logic ev, input logic [FLIT_W-1:0] ef);
        chk(v == ev && (!ev || f == ef), req, {v, f}, {ev, ef});
    endtask

    task automatic drive(input logic xv, input logic [FLIT_W-1:0] xf,
                         input logic yv, input logic [FLIT_W-1:0] yf,
                         input logic iv, input logic [FLIT_W-1:0] inf);
        x_in_vld = xv; x_in_flit = xf;
        y_in_vld = yv; y_in_flit = yf;
        inj_vld  = iv; inj_flit  = inf;
        #1;
    endtask

    task automatic idle();
        drive(0, '0, 0, '0, 0, '0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk_out("R10 x_out", x_out_vld, x_out_flit, 0, '0);
        chk_out("R10 y_out", y_out_vld, y_out_flit, 0, '0);
        chk_out("R10 eject", ej_vld, ej_flit, 0, '0);
        drive(0, '0, 0, '0, 1, mk(0, 0, 1));
        chk(inj_rdy == 0, "R10 inj_rdy", {1'b0, inj_rdy}, '0);
        idle();
        rst_n = 1'b1;
    endtask

    task automatic t_x_pass();
        drive(1, mk(2, 0, 16'hA1A1), 0, '0, 0, '0);
        @(negedge clk);
        chk_out("R1 pass", x_out_vld, x_out_flit, 1, mk(2, 0, 16'hA1A1));
        chk_out("R1 no eject", ej_vld, ej_flit, 0, '0);
        idle();
        @(negedge clk);
        chk_out("R1 idle", x_out_vld, x_out_flit, 0, '0);
    endtask

    task automatic t_y_prio();
        drive(1, mk(XP, 0, 16'h7001), 0, '0, 0, '0);
        @(negedge clk);
        chk_out("R5 queued not ejected", ej_vld, ej_flit, 0, '0);
        drive(0, '0, 1, mk(XP, 1, 16'hB0B0), 0, '0);
        @(negedge clk);
        chk_out("R2 through first", y_out_vld, y_out_flit, 1, mk(XP, 1, 16'hB0B0));
        idle();
        @(negedge clk);
        chk_out("R5 turn after", y_out_vld, y_out_flit, 1, mk(XP, 0, 16'h7001));
        @(negedge clk);
        chk_out("R5 drained", y_out_vld, y_out_flit, 0, '0);
    endtask

    task automatic t_eject();
        drive(1, mk(XP, YP, 16'hE001), 1, mk(XP, YP, 16'hE002), 0, '0);
        @(negedge clk);
        chk_out("R3 y wins", ej_vld, ej_flit, 1, mk(XP, YP, 16'hE002));
        chk_out("R4 x deflected", x_out_vld, x_out_flit, 1, mk(XP, YP, 16'hE001));
        drive(1, mk(XP, YP, 16'hE003), 0, '0, 0, '0);
        @(negedge clk);
        chk_out("R4 x eject", ej_vld, ej_flit, 1, mk(XP, YP, 16'hE003));
        chk_out("R4 no x", x_out_vld, x_out_flit, 0, '0);
        idle();
    endtask

    task automatic t_full();
        for (int c = 0; c < 6; c++) begin
            logic [FLIT_W-1:0] tf;
            tf = mk(XP, 0, 16'hC000 + c);
            if (c < 5) drive(1, tf, 1, mk(XP, 1, 16'hD000 + c), 0, '0);
            else       drive(0, '0, 1, mk(XP, 1, 16'hD000 + c), 1, mk(XP, 0, 16'hF00F));
            if (c == 5) chk(inj_rdy == 0, "R8 full blocks inject", {1'b0, inj_rdy}, '0);
            @(negedge clk);
            if (c == 4) chk_out("R6 overflow circulates", x_out_vld, x_out_flit, 1, tf);
            else if (c < 4) chk_out("R5 pushed", x_out_vld, x_out_flit, 0, '0);
        end
        idle();
        for (int k = 0; k < QD; k++) begin
            @(negedge clk);
            chk_out("R5 drain order", y_out_vld, y_out_flit, 1, mk(XP, 0, 16'hC000 + k));
        end
        @(negedge clk);
        chk_out("R8 blocked flit absent", y_out_vld, y_out_flit, 0, '0);
    endtask

    task automatic t_inject();
        drive(0, '0, 0, '0, 1, mk(0, 1, 16'h1111));
        chk(inj_rdy == 1, "R7 ready free", {1'b0, inj_rdy}, {1'b0, 1'b1});
        @(negedge clk);
        chk_out("R7 out", x_out_vld, x_out_flit, 1, mk(0, 1, 16'h1111));
        drive(1, mk(2, 2, 16'h2222), 0, '0, 1, mk(0, 1, 16'h3333));
        chk(inj_rdy == 0, "R7 ready busy", {1'b0, inj_rdy}, '0);
        @(negedge clk);
        chk_out("R7 ring wins", x_out_vld, x_out_flit, 1, mk(2, 2, 16'h2222));
        drive(0, '0, 0, '0, 1, mk(XP, 0, 16'h4444));
        chk(inj_rdy == 1, "R8 ready", {1'b0, inj_rdy}, {1'b0, 1'b1});
        @(negedge clk);
        idle();
        @(negedge clk);
        chk_out("R8 via queue", y_out_vld, y_out_flit, 1, mk(XP, 0, 16'h4444));
        drive(1, mk(XP, 1, 16'h5555), 0, '0, 1, mk(XP, 0, 16'h6666));
        chk(inj_rdy == 0, "R8 turn conflict", {1'b0, inj_rdy}, '0);
        @(negedge clk);
        idle();
        @(negedge clk);
        chk_out("R8 ring turn kept", y_out_vld, y_out_flit, 1, mk(XP, 1, 16'h5555));
        @(negedge clk);
        chk_out("R8 dropped flit absent", y_out_vld, y_out_flit, 0, '0);
    endtask

    task automatic t_self();
        drive(0, '0, 0, '0, 1, mk(XP, YP, 16'h7777));
        chk(inj_rdy == 1, "R9 ready", {1'b0, inj_rdy}, {1'b0, 1'b1});
        @(negedge clk);
        chk_out("R9 eject", ej_vld, ej_flit, 1, mk(XP, YP, 16'h7777));
        drive(0, '0, 1, mk(XP, YP, 16'h8888), 1, mk(XP, YP, 16'h9999));
        chk(inj_rdy == 0, "R9 busy", {1'b0, inj_rdy}, '0);
        @(negedge clk);
        chk_out("R9 ring eject", ej_vld, ej_flit, 1, mk(XP, YP, 16'h8888));
        idle();
        @(negedge clk);
        chk_out("R9 nothing extra", ej_vld, ej_flit, 0, '0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk);
        t_x_pass();
        t_y_prio();
        t_eject();
        @(negedge clk);
        t_full();
        t_inject();
        t_self();
        finish_run();
    end
endmodule